// File: doc/BRIEF.md
# Packed Saturating Add, Subtract and Multiply-Add Unit

This block does packed integer arithmetic on two 64-bit vectors. Each vector is split into lanes of 8, 16 or 32 bits, and all lanes are processed in the same cycle. No carry or borrow ever crosses from one lane into the next. Add and subtract can wrap around, clamp to signed limits or clamp to unsigned limits. Each lane clamps on its own, so one lane hitting a limit does not change any other lane.

A second operation, multiply-add, reads each operand as four signed 16-bit elements. It forms the four 32-bit products of matching elements. It then adds neighbouring products, which gives two 32-bit partial dot products.

An operation is issued by raising `in_valid_i` for one cycle, with the opcode, lane size and operands on the inputs. Add and subtract take one cycle. Multiply-add takes two cycles: its products are registered in between. `out_valid_o` is raised for one cycle when each result appears.

Top module: `pmac_unit`

## Requirements
- R1: During reset and in the first cycle after reset is released, `out_valid_o` is 0 and `out_data_o` is all zeros.
- R2: `op_i[1:0]` selects the mode: 00 wrap, 01 signed saturate, 10 unsigned saturate, 11 multiply-add. In the first three modes, `op_i[2]` set to 1 means opa minus opb, and 0 means opa plus opb. `size_i` selects the lane width: 00 is 8 bits, 01 is 16 bits, 10 and 11 are 32 bits. Lane i occupies bits [i*W +: W].
- R3: In wrap mode, each lane holds (a ± b) modulo 2^W. No carry or borrow reaches the neighbouring lane, at any lane width.
- R4: In signed saturate mode, 8-bit lanes clamp to 0x7F and 0x80, and 16-bit lanes clamp to 0x7FFF and 0x8000. The clamp is decided per lane.
- R5: In unsigned saturate mode, an add that overflows gives all ones in that lane, and a subtract that underflows gives zero. The clamp is decided per lane.
- R6: With 32-bit lanes, both saturate modes behave exactly like wrap mode.
- R7: In multiply-add mode, result bits [32j +: 32] hold the sum of the products of 16-bit elements 2j and 2j+1 of opa and opb. The elements are treated as signed. The sum wraps, so when all inputs are 0x8000 the result is 0x80000000. `size_i` and `op_i[2]` have no effect in this mode.
- R8: An add or subtract result appears with `out_valid_o` high in the cycle after it is issued. A multiply-add result appears two cycles after it is issued. Each result is valid for exactly one cycle.
- R9: If an add or subtract is issued in the cycle right after a multiply-add, both would be due in the same cycle. In that case the multiply-add result is output, and the add or subtract is discarded.
- R10: In a cycle where no result is due, `out_valid_o` is 0 and `out_data_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Issues an operation this cycle |
| op_i | input | 3 | Bit 2 selects subtract; bits 1:0 select the mode |
| size_i | input | 2 | Lane width select |
| opa_i | input | 64 | First operand vector |
| opb_i | input | 64 | Second operand vector |
| out_valid_o | output | 1 | Result valid strobe |
| out_data_o | output | 64 | Result vector |

## Verification
The bound checker checks the following on every cycle:
- the reset output values;
- the latency of both kinds of operation;
- that nothing appears and the data holds still on idle cycles;
- the direction of unsigned clamping on 8-bit lanes: an add result never falls below the first operand, and a subtract result never rises above it.

Some behaviours can only be shown by the bench's scenarios, which compare every cycle against a behavioural model:
- the exact clamp values;
- the isolation between lanes;
- the signed multiply-add sums, including the all-0x8000 case;
- the 32-bit lanes ignoring the saturate modes;
- the priority rule when two results are due in the same cycle.

// File: rtl/pmac_pkg.sv
// Shared types for the packed arithmetic unit.
// Assumes op[1:0] carries the mode and size uses the 2-bit encoding below.
package pmac_pkg;

    typedef enum logic [1:0] {
        MODE_WRAP = 2'b00,
        MODE_SSAT = 2'b01,
        MODE_USAT = 2'b10,
        MODE_MADD = 2'b11
    } pmac_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_DWALT = 2'b11
    } pmac_size_e;

    localparam int NUM_SIZES = 3;

endpackage

// File: rtl/pmac_sat_lane.sv
// One lane of W bits: adds or subtracts, then wraps or clamps.
// Assumes mode MADD never reaches it meaningfully (it falls back to wrap).
module pmac_sat_lane
    import pmac_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       [W-1:0] a_i,
    input  logic       [W-1:0] b_i,
    input  logic               sub_i,
    input  pmac_mode_e         mode_i,
    output logic       [W-1:0] y_o
);

    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ext_u;
    logic [W:0] ext_s;

    // Forms the one-bit-wider results, zero-extended and sign-extended.
    always_comb begin
        if (sub_i) begin
            ext_u = {1'b0, a_i} - {1'b0, b_i};
            ext_s = {a_i[W-1], a_i} - {b_i[W-1], b_i};
        end else begin
            ext_u = {1'b0, a_i} + {1'b0, b_i};
            ext_s = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        end
    end

    // Picks the wrapped value or the clamp limit for this lane.
    always_comb begin
        case (mode_i)
            MODE_SSAT: begin
                if (ext_s[W] != ext_s[W-1]) y_o = ext_s[W] ? SMIN : SMAX;
                else                        y_o = ext_s[W-1:0];
            end
            MODE_USAT: begin
                if (ext_u[W]) y_o = sub_i ? '0 : '1;
                else          y_o = ext_u[W-1:0];
            end
            default:   y_o = ext_u[W-1:0];
        endcase
    end

endmodule

// File: rtl/pmac_addsub.sv
// Packed add/subtract for all lane widths in parallel, then a select by size.
// Assumes DATA_W is a multiple of 32; 32-bit lanes always wrap.
module pmac_addsub
    import pmac_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic       [DATA_W-1:0] a_i,
    input  logic       [DATA_W-1:0] b_i,
    input  logic                    sub_i,
    input  pmac_mode_e              mode_i,
    input  pmac_size_e              size_i,
    output logic       [DATA_W-1:0] y_o
);

    logic [NUM_SIZES-1:0][DATA_W-1:0] res_sz;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int LW    = 8 << k;
        localparam int LANES = DATA_W / LW;
        pmac_mode_e lane_mode;
        assign lane_mode = (k == NUM_SIZES - 1) ? MODE_WRAP : mode_i;
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            pmac_sat_lane #(.W(LW)) u_lane (
                .a_i    (a_i[i*LW +: LW]),
                .b_i    (b_i[i*LW +: LW]),
                .sub_i  (sub_i),
                .mode_i (lane_mode),
                .y_o    (res_sz[k][i*LW +: LW])
            );
        end
    end

    // Chooses the result vector that matches the requested lane width.
    always_comb begin
        case (size_i)
            SZ_BYTE: y_o = res_sz[0];
            SZ_WORD: y_o = res_sz[1];
            default: y_o = res_sz[2];
        endcase
    end

endmodule

// File: rtl/pmac_madd.sv
// First stage of multiply-add: registers the signed 16x16 products.
// Combinational pairwise sums feed the shared output register (stage two).
module pmac_madd #(
    parameter int DATA_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              pend_o,
    output logic [DATA_W-1:0] sum_o
);

    localparam int NPROD = DATA_W / 16;
    localparam int NSUM  = DATA_W / 32;

    logic signed [31:0] prod_q [NPROD];
    logic               pend_q;

    function automatic logic signed [31:0] mul16(input logic signed [15:0] x,
                                                 input logic signed [15:0] y);
        logic signed [31:0] xe;
        logic signed [31:0] ye;
        xe = 32'(x);
        ye = 32'(y);
        return xe * ye;
    endfunction

    // Captures the products of an issued multiply-add and marks them pending.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
            for (int i = 0; i < NPROD; i++) prod_q[i] <= '0;
        end else begin
            pend_q <= issue_i;
            if (issue_i) begin
                for (int i = 0; i < NPROD; i++)
                    prod_q[i] <= mul16(a_i[16*i +: 16], b_i[16*i +: 16]);
            end
        end
    end

    // Adds neighbouring products into each 32-bit result lane, wrapping.
    always_comb begin
        for (int j = 0; j < NSUM; j++)
            sum_o[32*j +: 32] = prod_q[2*j] + prod_q[2*j+1];
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/pmac_unit.sv
// Top of the packed arithmetic unit. Add/subtract lands in one cycle;
// multiply-add lands in two, and wins when both are due in the same cycle.
// Assumes DATA_W is a multiple of 32.
module pmac_unit
    import pmac_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o
);

    pmac_mode_e        mode;
    pmac_size_e        size;
    logic              is_madd;
    logic [DATA_W-1:0] as_res;
    logic [DATA_W-1:0] madd_sum;
    logic              madd_pend;
    logic              out_valid_q;
    logic [DATA_W-1:0] out_data_q;

    assign mode    = pmac_mode_e'(op_i[1:0]);
    assign size    = pmac_size_e'(size_i);
    assign is_madd = (mode == MODE_MADD);

    pmac_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .sub_i  (op_i[2]),
        .mode_i (mode),
        .size_i (size),
        .y_o    (as_res)
    );

    pmac_madd #(.DATA_W(DATA_W)) u_madd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .issue_i (in_valid_i && is_madd),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .pend_o  (madd_pend),
        .sum_o   (madd_sum)
    );

    // Output register: madd stage two first, else a one-cycle result, else hold.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else if (madd_pend) begin
            out_valid_q <= 1'b1;
            out_data_q  <= madd_sum;
        end else if (in_valid_i && !is_madd) begin
            out_valid_q <= 1'b1;
            out_data_q  <= as_res;
        end else begin
            out_valid_q <= 1'b0;
        end
    end

    assign out_valid_o = out_valid_q;
    assign out_data_o  = out_data_q;

endmodule

// File: rtl/pmac_chk.sv
// Checker for pmac_unit, watching its ports only; attached by bind below.
module pmac_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              in_valid_i,
    input logic [2:0]        op_i,
    input logic [1:0]        size_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] out_data_o
);

    logic was_rst_q;
    logic madd_prev_q;
    logic as_issue;
    logic clean_as;

    // Remembers whether the previous edge was taken under reset.
    always_ff @(posedge clk_i) was_rst_q <= !rst_ni;

    // Remembers a multiply-add issued on the previous edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) madd_prev_q <= 1'b0;
        else         madd_prev_q <= in_valid_i && (op_i[1:0] == 2'b11);
    end

    assign as_issue = in_valid_i && (op_i[1:0] != 2'b11);
    assign clean_as = as_issue && !madd_prev_q && (size_i == 2'b00);

    // R1: outputs cleared straight after reset
    a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        was_rst_q |-> (!out_valid_o && out_data_o == '0));

    // R8: add/subtract result valid one cycle later
    a_r8_addsub_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        as_issue |=> out_valid_o);

    // R8: multiply-add result valid two cycles after issue
    a_r8_madd_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        madd_prev_q |=> out_valid_o);

    // R10: nothing due means no strobe and steady data
    a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_valid_i && !madd_prev_q) |=> (!out_valid_o && $stable(out_data_o)));

    for (genvar i = 0; i < DATA_W / 8; i++) begin : g_byte
        // R5: unsigned saturating add never drops below the first operand
        a_r5_usat_add_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clean_as && op_i == 3'b010) |=>
                (out_data_o[i*8 +: 8] >= $past(opa_i[i*8 +: 8])));
        // R5: unsigned saturating subtract never rises above the first operand
        a_r5_usat_sub_ceil: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clean_as && op_i == 3'b110) |=>
                (out_data_o[i*8 +: 8] <= $past(opa_i[i*8 +: 8])));
    end

endmodule

bind pmac_unit pmac_chk #(.DATA_W(DATA_W)) u_pmac_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .op_i        (op_i),
    .size_i      (size_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
);

// File: tb/test_pmac_unit.sv
`timescale 1ns/1ps
module test_pmac_unit;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic        out_valid_o;
    logic [63:0] out_data_o;

    int          n_checks = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          done = 0;
    logic        slot_v [4];
    logic [63:0] slot_d [4];
    string       slot_r [4];
    logic [63:0] last_d = '0;

    always #2.5 clk_i = ~clk_i;

    pmac_unit i_pmac_unit (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .in_valid_i  (in_valid_i),
        .op_i        (op_i),
        .size_i      (size_i),
        .opa_i       (opa_i),
        .opb_i       (opb_i),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o)
    );

    // Behavioural model of one operation, from the requirements.
    function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] sz,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] res = '0;
        if (op[1:0] == 2'b11) begin
            for (int j = 0; j < 2; j++) begin
                longint s = 0;
                for (int k = 0; k < 2; k++) begin
                    longint x = longint'((a >> (16*(2*j+k))) & 64'hFFFF);
                    longint y = longint'((b >> (16*(2*j+k))) & 64'hFFFF);
                    if (x >= 32768) x = x - 65536;
                    if (y >= 32768) y = y - 65536;
                    s = s + x * y;
                end
                res = res | (64'(s & 64'hFFFF_FFFF) << (32*j));
            end
        end else begin
            int     w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
            int     md   = (w == 32) ? 0 : int'(op[1:0]);
            longint full = longint'(64'd1) << w;
            longint mask = full - 1;
            for (int i = 0; i < 64 / w; i++) begin
                longint ua = longint'((a >> (i*w))) & mask;
                longint ub = longint'((b >> (i*w))) & mask;
                longint sa = (ua >= full / 2) ? ua - full : ua;
                longint sb = (ub >= full / 2) ? ub - full : ub;
                longint r;
                if (md == 1) begin
                    r = op[2] ? sa - sb : sa + sb;
                    if (r > full / 2 - 1) r = full / 2 - 1;
                    if (r < -(full / 2)) r = -(full / 2);
                end else if (md == 2) begin
                    r = op[2] ? ua - ub : ua + ub;
                    if (r > mask) r = mask;
                    if (r < 0) r = 0;
                end else begin
                    r = op[2] ? ua - ub : ua + ub;
                end
                res = res | (64'(r & mask) << (i*w));
            end
        end
        return res;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [64:0] act, input logic [64:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (bit 64 = valid)", req, act, exp);
        end
    endtask

    // Compares the outputs after an edge with the slot the model filled.
    task automatic check_slot();
        int s = cyc % 4;
        if (slot_v[s]) begin
            check(out_valid_o === 1'b1 && out_data_o === slot_d[s], slot_r[s],
                  {out_valid_o, out_data_o}, {1'b1, slot_d[s]});
            last_d = slot_d[s];
        end else begin
            check(out_valid_o === 1'b0 && out_data_o === last_d, "R10",
                  {out_valid_o, out_data_o}, {1'b0, last_d});
        end
        slot_v[s] = 1'b0;
    endtask

    // Drives one cycle of input, books the expected result, then checks.
    task automatic step(input logic v, input logic [2:0] op, input logic [1:0] sz,
                        input logic [63:0] a, input logic [63:0] b, input string req);
        in_valid_i = v;
        op_i       = op;
        size_i     = sz;
        opa_i      = a;
        opb_i      = b;
        if (v) begin
            int lat = (op[1:0] == 2'b11) ? 2 : 1;
            int s   = (cyc + lat) % 4;
            if (lat == 2 || !slot_v[s]) begin
                slot_v[s] = 1'b1;
                slot_d[s] = model(op, sz, a, b);
                slot_r[s] = req;
            end
        end
        @(posedge clk_i);
        cyc++;
        @(negedge clk_i);
        check_slot();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'b000, 2'b00, '0, '0, "R10");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            slot_v[i] = 1'b0;
            slot_d[i] = '0;
            slot_r[i] = "";
        end
        repeat (3) @(negedge clk_i);
        // R1: reset state
        check(out_valid_o === 1'b0 && out_data_o === '0, "R1",
              {out_valid_o, out_data_o}, 65'd0);
        rst_ni = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        // R1: first cycle after release
        check(out_valid_o === 1'b0 && out_data_o === '0, "R1",
              {out_valid_o, out_data_o}, 65'd0);

        // R3: wrap, lanes isolated at every width
        step(1, 3'b000, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R3");
        step(1, 3'b100, 2'b01, 64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, "R3");
        step(1, 3'b000, 2'b10, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, "R3");
        step(1, 3'b000, 2'b11, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_8000_0000, "R3");
        // R4: signed clamps, byte and word, mixed lanes
        step(1, 3'b001, 2'b00, 64'h7F80_7F80_0102_7F00, 64'h0101_FFFF_0102_8180, "R4");
        step(1, 3'b101, 2'b00, 64'h807F_0010_8000_7F7F, 64'h01FF_0020_7F80_80FF, "R4");
        step(1, 3'b001, 2'b01, 64'h7FFF_8000_1234_7000, 64'h0001_FFFF_0001_1000, "R4");
        step(1, 3'b101, 2'b01, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0003_8000, "R4");
        // R5: unsigned clamps
        step(1, 3'b010, 2'b00, 64'hFF80_0102_F00F_7F01, 64'h0180_0304_20F1_80FE, "R5");
        step(1, 3'b110, 2'b00, 64'h0080_0304_F00F_7F01, 64'h0181_0102_F010_0002, "R5");
        step(1, 3'b010, 2'b01, 64'hFFFF_8000_0001_1234, 64'h0001_8000_FFFE_0001, "R5");
        step(1, 3'b110, 2'b01, 64'h0000_8000_0005_1234, 64'h0001_7FFF_0006_1234, "R5");
        // R6: 32-bit lanes ignore saturate modes
        step(1, 3'b001, 2'b10, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R6");
        step(1, 3'b110, 2'b10, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0002, "R6");
        step(1, 3'b010, 2'b11, 64'hFFFF_FFFF_0000_0000, 64'h0000_0002_0000_0000, "R6");
        idle(2);
        // R7: multiply-add, signed, and the all-0x8000 case
        step(1, 3'b011, 2'b01, 64'h0003_FFFE_0100_0002, 64'h0004_0005_FF00_7FFF, "R7");
        idle(2);
        step(1, 3'b011, 2'b01, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R7");
        idle(2);
        step(1, 3'b111, 2'b00, 64'h7FFF_7FFF_8000_7FFF, 64'h7FFF_7FFF_7FFF_8000, "R7");
        // R8: latency, back-to-back multiply-adds then mixed traffic
        step(1, 3'b011, 2'b10, 64'h1111_2222_3333_4444, 64'h0002_0003_0004_0005, "R8");
        step(1, 3'b011, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, "R8");
        idle(2);
        step(1, 3'b000, 2'b00, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, "R8");
        step(1, 3'b011, 2'b01, 64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008, "R8");
        idle(2);
        // R9: add issued right behind a multiply-add is dropped
        step(1, 3'b011, 2'b01, 64'h0010_0020_0030_0040, 64'h0002_0002_0002_0002, "R9");
        step(1, 3'b000, 2'b00, 64'hAAAA_AAAA_AAAA_AAAA, 64'h1111_1111_1111_1111, "R9");
        step(1, 3'b100, 2'b01, 64'h0009_0009_0009_0009, 64'h0001_0001_0001_0001, "R9");
        // R10: idle gaps hold the last value
        idle(3);
        // R2: mixed random traffic across every opcode and size
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  rop = 3'($urandom);
            logic [1:0]  rsz = 2'($urandom);
            logic [63:0] ra  = {$urandom, $urandom};
            logic [63:0] rb  = {$urandom, $urandom};
            logic        rv  = ($urandom % 4) != 0;
            if (n % 7 == 0) ra = {8{8'h7F}};
            if (n % 11 == 0) rb = {8{8'h80}};
            step(rv, rop, rsz, ra, rb, "R2");
        end
        idle(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk_i);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule